// File: doc/BRIEF.md
# Dual Edge Input Capture Channel Pair

This block timestamps transitions on a single input pin against an external free-running counter, using two capture registers in a fixed order. The first register takes the counter value on the edge chosen by the first edge select. The second register takes the counter value on the edge chosen by the second edge select, but only while the first flag is still set. If both selects name the same edge, the two stamps bound one period of the signal. If they name different edges, the two stamps bound one pulse.

The pin passes through a two-flop synchronizer. On channel pairs that carry a glitch filter, it then passes through that filter before edge detection. Captures are either one-shot, where software arms the pair and the arm bit drops after the second stamp, or continuous, where stamps repeat without re-arming. Each flag drives an interrupt output through its own enable. A flag is cleared in one of two ways, depending on the DMA mode input. With DMA mode on, a DMA-done pulse clears it. With DMA mode off, software must read the status while the flag is set and then write a 0 to the flag's bit.

The register port is a plain strobe interface with a combinational read mux. There is no streaming path: the captured values are state that software polls, so no valid/ready handshake or back-pressure applies.

Top module: `dcap_pair`

## Requirements
- R1: When the global enable and the dual-capture enable are not both 1, edges on the pin change neither capture register nor either flag, and the pending second-capture step is abandoned.
- R2: Edge select codes are 00 = none, 01 = rising, 10 = falling, 11 = both. With the filter off, an edge on the pin is stamped with the counter value present at the third rising clock edge after the pin changed (two synchronizer flops and one edge-detect flop).
- R3: A second capture (register B, flag B) happens only on a B-selected edge while the first flag is set and a first capture is pending. If flag A is cleared while the pair waits, B-selected edges are ignored and the next A-selected edge restarts the pair with a new first capture.
- R4: Equal edge selects give a period measurement (B holds the next same-direction edge). Different selects give a width measurement (B holds the opposite edge that follows).
- R5: With the continuous input at 0, captures happen only while the arm bit is 1. Writing 1 to status bit 0 sets arm and restarts the pair. Arm clears itself on the second capture.
- R6: With the continuous input at 1, the arm bit is not needed. Each new first capture overwrites register A, and register B keeps its last value until the next second capture.
- R7: irq_a_o is flag A AND irq_en_a_i, and irq_b_o is flag B AND irq_en_b_i.
- R8: With DMA mode off, a flag clears only when a status read (address 0) saw it set and a later status write has its bit at 0 (bit 1 = flag A, bit 2 = flag B). Writing 1 to a flag bit, or writing 0 without a prior read, has no effect.
- R9: With DMA mode on, register writes never clear a flag. A one-cycle dma_done pulse clears the matching flag.
- R10: With the filter built in (PAIR_ID 0 or 1) and enabled, a level that lasts fewer than FILT_CYCLES clock cycles is dropped. A longer level is stamped FILT_CYCLES cycles later than in R2.
- R11: Status reads at address 0 return {flag B, flag A, arm} in bits 2..0. Address 1 reads capture A, address 2 reads capture B, and address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| count_i | input | CNT_W | Free-running counter value to stamp |
| pin_i | input | 1 | Measured signal, asynchronous |
| feat_en_i | input | 1 | Global timer feature enable |
| dual_en_i | input | 1 | Dual-edge capture enable |
| cont_mode_i | input | 1 | 1 = continuous, 0 = one-shot |
| edge_sel_a_i | input | 2 | Edge select of first capture |
| edge_sel_b_i | input | 2 | Edge select of second capture |
| filt_en_i | input | 1 | Glitch filter enable |
| dma_mode_i | input | 1 | 1 = flags cleared by DMA done |
| dma_done_a_i | input | 1 | DMA transfer done for flag A |
| dma_done_b_i | input | 1 | DMA transfer done for flag B |
| irq_en_a_i | input | 1 | Interrupt enable A |
| irq_en_b_i | input | 1 | Interrupt enable B |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 3 | Status write data |
| reg_rdata_o | output | CNT_W | Register read data |
| irq_a_o | output | 1 | Interrupt of first capture |
| irq_b_o | output | 1 | Interrupt of second capture |

## Verification
The hardest state to reach is the one where flag A is cleared while the pair is waiting for its second edge. That state exercises both the second-capture gate and the restart by a new first capture. A directed sequence gets there by stamping a rising edge, then doing the status read and the zero write before the falling edge arrives. The filter boundary gets the same treatment: a pulse one cycle shorter than the filter window is followed by a long pulse, and the exact stamp values are checked. Random toggling of the pin under random selects, modes and enables then checks the ordering rules against a cycle model in the bench.

// File: rtl/dcap_pkg.sv
package dcap_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam logic [1:0] ADDR_STAT  = 2'd0;
  localparam logic [1:0] ADDR_CAP_A = 2'd1;
  localparam logic [1:0] ADDR_CAP_B = 2'd2;

  localparam int unsigned BIT_ARM    = 0;
  localparam int unsigned BIT_FLAG_A = 1;
  localparam int unsigned BIT_FLAG_B = 2;
  localparam int unsigned NUM_CH     = 2;
  localparam int unsigned STAT_W     = 3;

  function automatic logic edge_hit(input edge_sel_e sel, input logic rise,
                                    input logic fall);
    logic hit;
    unique case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/dcap_sync.sv
module dcap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/dcap_filter.sv
module dcap_filter #(
  parameter int unsigned LEN     = 4,
  parameter bit          PRESENT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = (LEN < 2) ? 1 : $clog2(LEN);

  generate
    if (PRESENT) begin : g_filt
      logic          filt_q;
      logic [CW-1:0] run_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          filt_q <= 1'b0;
          run_q  <= '0;
        end else if (!en_i || (d_i == filt_q)) begin
          filt_q <= d_i;
          run_q  <= '0;
        end else if (run_q == CW'(LEN - 1)) begin
          filt_q <= d_i;
          run_q  <= '0;
        end else begin
          run_q <= run_q + 1'b1;
        end
      end

      assign q_o = en_i ? filt_q : d_i;

      if (LEN >= 2) begin : g_chk
        // R10: an enabled output change needs the input at the new level two cycles back
        p_filter_stable_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
          ($changed(filt_q) && $past(en_i) && $past(en_i, 2)) |-> ($past(d_i, 2) == filt_q));
      end
    end else begin : g_bypass
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/dcap_edge.sv
module dcap_edge
  import dcap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       d_i,
  input  logic [1:0] sel_a_i,
  input  logic [1:0] sel_b_i,
  output logic       hit_a_o,
  output logic       hit_b_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= d_i;
  end

  assign rise    = d_i & ~prev_q;
  assign fall    = ~d_i & prev_q;
  assign hit_a_o = edge_hit(edge_sel_e'(sel_a_i), rise, fall);
  assign hit_b_o = edge_hit(edge_sel_e'(sel_b_i), rise, fall);
endmodule

// File: rtl/dcap_seq.sv
module dcap_seq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic cont_i,
  input  logic arm_set_i,
  input  logic flag_a_i,
  input  logic hit_a_i,
  input  logic hit_b_i,
  output logic cap_first_o,
  output logic cap_second_o,
  output logic arm_o
);
  logic arm_q, wait_q, allow;

  assign allow        = active_i & (cont_i | arm_q);
  assign cap_second_o = allow & wait_q & flag_a_i & hit_b_i;
  assign cap_first_o  = allow & ~cap_second_o & hit_a_i & (~wait_q | ~flag_a_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= 1'b0;
      wait_q <= 1'b0;
    end else begin
      if (arm_set_i)                     arm_q <= 1'b1;
      else if (cap_second_o && !cont_i)  arm_q <= 1'b0;

      if (!active_i || arm_set_i) wait_q <= 1'b0;
      else if (cap_second_o)      wait_q <= 1'b0;
      else if (cap_first_o)       wait_q <= 1'b1;
    end
  end

  assign arm_o = arm_q;

  // R5: arm only drops through a one-shot second capture
  p_arm_selfclear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(arm_q) |-> ($past(cap_second_o) && !$past(cont_i)));
endmodule

// File: rtl/dcap_flag.sv
module dcap_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic dma_mode_i,
  input  logic dma_done_i,
  input  logic stat_rd_i,
  input  logic stat_wr_i,
  input  logic wr_bit_i,
  output logic flag_o
);
  logic flag_q, seen_q, clr;

  assign clr = dma_mode_i ? dma_done_i : (stat_wr_i & ~wr_bit_i & seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      if (set_i)    flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;

      if (clr && !set_i)            seen_q <= 1'b0;
      else if (stat_rd_i && flag_q) seen_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  // R9: in DMA mode only the done pulse clears the flag
  p_dma_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_mode_i && !dma_done_i && flag_q) |=> flag_q);
  // R8: a software clear needs a preceding status read
  p_sw_clear_needs_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(flag_q) && !$past(dma_mode_i)) |-> $past(seen_q));
endmodule

// File: rtl/dcap_pair.sv
module dcap_pair
  import dcap_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned FILT_CYCLES = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned PAIR_ID     = 0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CNT_W-1:0]    count_i,
  input  logic                pin_i,
  input  logic                feat_en_i,
  input  logic                dual_en_i,
  input  logic                cont_mode_i,
  input  logic [1:0]          edge_sel_a_i,
  input  logic [1:0]          edge_sel_b_i,
  input  logic                filt_en_i,
  input  logic                dma_mode_i,
  input  logic                dma_done_a_i,
  input  logic                dma_done_b_i,
  input  logic                irq_en_a_i,
  input  logic                irq_en_b_i,
  input  logic                reg_rd_i,
  input  logic                reg_wr_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [STAT_W-1:0]   reg_wdata_i,
  output logic [CNT_W-1:0]    reg_rdata_o,
  output logic                irq_a_o,
  output logic                irq_b_o
);
  localparam bit HAS_FILTER = (PAIR_ID < 2);

  logic pin_sync, pin_clean, hit_a, hit_b;
  logic active, stat_rd, stat_wr, arm_set, arm;
  logic cap_first, cap_second;
  logic [CNT_W-1:0]  cap_a_q, cap_b_q;
  logic [NUM_CH-1:0] flag_set, flag_done, flag_bit, flag;

  dcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_sync));

  dcap_filter #(.LEN(FILT_CYCLES), .PRESENT(HAS_FILTER)) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(filt_en_i), .d_i(pin_sync), .q_o(pin_clean));

  dcap_edge u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_clean),
    .sel_a_i(edge_sel_a_i), .sel_b_i(edge_sel_b_i),
    .hit_a_o(hit_a), .hit_b_o(hit_b));

  assign active  = feat_en_i & dual_en_i;
  assign stat_rd = reg_rd_i & (reg_addr_i == ADDR_STAT);
  assign stat_wr = reg_wr_i & (reg_addr_i == ADDR_STAT);
  assign arm_set = stat_wr & reg_wdata_i[BIT_ARM];

  dcap_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(active), .cont_i(cont_mode_i),
    .arm_set_i(arm_set), .flag_a_i(flag[0]), .hit_a_i(hit_a), .hit_b_i(hit_b),
    .cap_first_o(cap_first), .cap_second_o(cap_second), .arm_o(arm));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_a_q <= '0;
      cap_b_q <= '0;
    end else begin
      if (cap_first)  cap_a_q <= count_i;
      if (cap_second) cap_b_q <= count_i;
    end
  end

  assign flag_set  = {cap_second, cap_first};
  assign flag_done = {dma_done_b_i, dma_done_a_i};
  assign flag_bit  = reg_wdata_i[BIT_FLAG_B:BIT_FLAG_A];

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_flag
      dcap_flag u_flag (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(flag_set[ch]),
        .dma_mode_i(dma_mode_i), .dma_done_i(flag_done[ch]),
        .stat_rd_i(stat_rd), .stat_wr_i(stat_wr), .wr_bit_i(flag_bit[ch]),
        .flag_o(flag[ch]));
    end
  endgenerate

  assign irq_a_o = flag[0] & irq_en_a_i;
  assign irq_b_o = flag[1] & irq_en_b_i;

  always_comb begin
    unique case (reg_addr_i)
      ADDR_STAT:  reg_rdata_o = {{(CNT_W-STAT_W){1'b0}}, flag[1], flag[0], arm};
      ADDR_CAP_A: reg_rdata_o = cap_a_q;
      ADDR_CAP_B: reg_rdata_o = cap_b_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  // R1: no capture while the mode is off
  p_inactive_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(feat_en_i && dual_en_i) |=> ($stable(cap_a_q) && $stable(cap_b_q)));
  // R3: flag B only rises when flag A was set
  p_second_needs_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag[1]) |-> $past(flag[0]));
  // R5: one-shot and unarmed leaves both stamps alone
  p_oneshot_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cont_mode_i && !arm) |=> ($stable(cap_a_q) && $stable(cap_b_q)));
endmodule

// File: tb/dcap_pair_tb.sv
module dcap_pair_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int F = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cnt;
  logic pin = 0, feat = 1, dual = 1, cont = 0, filt = 0, dma = 0;
  logic [1:0] sel_a = 2'b01, sel_b = 2'b10;
  logic done_a = 0, done_b = 0, ien_a = 0, ien_b = 0;
  logic rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [2:0] wdata = 0;
  logic [15:0] rdata;
  logic irq_a, irq_b;
  int checks = 0, fails = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcap_pair #(.CNT_W(16), .FILT_CYCLES(F)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .count_i(cnt), .pin_i(pin), .feat_en_i(feat),
    .dual_en_i(dual), .cont_mode_i(cont), .edge_sel_a_i(sel_a), .edge_sel_b_i(sel_b),
    .filt_en_i(filt), .dma_mode_i(dma), .dma_done_a_i(done_a), .dma_done_b_i(done_b),
    .irq_en_a_i(ien_a), .irq_en_b_i(ien_b), .reg_rd_i(rd), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_a_o(irq_a), .irq_b_o(irq_b));

  always @(posedge clk) begin
    if (!rst_n) cnt <= 16'd0;
    else        cnt <= cnt + 16'd1;
  end

  // cycle model of the requirements (filter off)
  logic m_s1, m_s2, m_s3, m_arm, m_wait, m_fa, m_fb;
  logic [15:0] m_ca, m_cb;
  logic m_r, m_f, m_ha, m_hb, m_allow, m_sec;

  function automatic logic hit(input logic [1:0] s, input logic r, input logic f);
    return (s == 2'b01 && r) || (s == 2'b10 && f) || (s == 2'b11 && (r || f));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      {m_s1, m_s2, m_s3, m_arm, m_wait, m_fa, m_fb} = '0;
      m_ca = 0; m_cb = 0;
    end else begin
      m_r = m_s2 & ~m_s3;
      m_f = ~m_s2 & m_s3;
      m_ha = hit(sel_a, m_r, m_f);
      m_hb = hit(sel_b, m_r, m_f);
      m_allow = feat & dual & (cont | m_arm);
      m_sec = m_allow & m_wait & m_fa & m_hb;
      if (m_sec) begin
        m_cb = cnt; m_fb = 1; m_wait = 0;
        if (!cont) m_arm = 0;
      end else if (m_allow & m_ha & (~m_wait | ~m_fa)) begin
        m_ca = cnt; m_fa = 1; m_wait = 1;
      end
      if (!(feat & dual)) m_wait = 0;
      if (wr && addr == 2'd0 && wdata[0]) begin m_arm = 1; m_wait = 0; end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_pin(input logic v, output logic [15:0] c);
    @(negedge clk); pin = v; c = cnt;
  endtask

  task automatic sw_write(input logic [2:0] d);
    @(negedge clk); addr = 0; wdata = d; wr = 1;
    @(negedge clk); wr = 0; wdata = 0;
  endtask

  task automatic sw_read;
    @(negedge clk); addr = 0; rd = 1;
    @(negedge clk); rd = 0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0; idle(3); rst_n = 1; idle(2);
  endtask

  task automatic summary;
    if (!done_flag) begin
      done_flag = 1;
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [15:0] v, c1, c2, c3, c4, pa, pb;
    void'($urandom(32'd20240611));
    do_reset();
    @(negedge clk);
    peek(0, v); chk("R11 reset status", v, 16'h0);
    peek(1, v); chk("R11 reset capA", v, 16'h0);
    peek(3, v); chk("R11 addr3 zero", v, 16'h0);
    chk("R7 reset irq", {15'd0, irq_a | irq_b}, 16'h0);

    // one-shot width: rise -> A, fall -> B
    sw_write(3'b111); idle(3);
    drive_pin(1, c1); idle(5); drive_pin(0, c2); idle(5);
    peek(1, v); chk("R2 R4 width capA", v, c1 + 16'd2);
    peek(2, v); chk("R4 width capB", v, c2 + 16'd2);
    peek(0, v); chk("R5 arm self-clear", v, 16'h6);
    ien_a = 1; #1;
    chk("R7 irq_a", {15'd0, irq_a}, 16'h1);
    chk("R7 irq_b masked", {15'd0, irq_b}, 16'h0);
    drive_pin(1, c3); idle(5); drive_pin(0, c3); idle(5);
    peek(1, v); chk("R5 unarmed capA hold", v, c1 + 16'd2);
    peek(2, v); chk("R5 unarmed capB hold", v, c2 + 16'd2);

    // software clear rules
    sw_write(3'b100); @(negedge clk);
    peek(0, v); chk("R8 write without read", v, 16'h6);
    sw_read(); sw_write(3'b100); @(negedge clk);
    peek(0, v); chk("R8 clear A, keep B on 1", v, 16'h4);
    chk("R7 irq_a after clear", {15'd0, irq_a}, 16'h0);
    sw_write(3'b000); @(negedge clk);
    peek(0, v); chk("R8 clear B", v, 16'h0);

    // continuous period: rise, rise, rise
    cont = 1; sel_a = 2'b01; sel_b = 2'b01;
    drive_pin(1, c1); idle(4); drive_pin(0, v); idle(4);
    drive_pin(1, c2); idle(4); drive_pin(0, v); idle(4);
    drive_pin(1, c3); idle(4); drive_pin(0, v); idle(4);
    peek(1, v); chk("R6 capA overwritten", v, c3 + 16'd2);
    peek(2, v); chk("R4 period capB", v, c2 + 16'd2);
    peek(0, v); chk("R6 flags continuous", v, 16'h6);
    pa = c3 + 16'd2; pb = c2 + 16'd2;

    // DMA clear
    dma = 1; sw_read(); sw_write(3'b000); @(negedge clk);
    peek(0, v); chk("R9 write ignored in dma mode", v, 16'h6);
    @(negedge clk); done_a = 1; @(negedge clk); done_a = 0; @(negedge clk);
    peek(0, v); chk("R9 dma done A", v, 16'h4);
    @(negedge clk); done_b = 1; @(negedge clk); done_b = 0; @(negedge clk);
    peek(0, v); chk("R9 dma done B", v, 16'h0);
    dma = 0;

    // mode off
    dual = 0;
    drive_pin(1, v); idle(4); drive_pin(0, v); idle(4);
    peek(1, v); chk("R1 dual off capA", v, pa);
    peek(0, v); chk("R1 dual off flags", v, 16'h0);
    dual = 1; feat = 0;
    drive_pin(1, v); idle(4); drive_pin(0, v); idle(4);
    peek(1, v); chk("R1 feat off capA", v, pa);
    peek(2, v); chk("R1 feat off capB", v, pb);
    feat = 1; idle(2);

    // flag A cleared while waiting for B
    sel_a = 2'b01; sel_b = 2'b10;
    drive_pin(1, c1); idle(4);
    sw_read(); sw_write(3'b100); idle(2);
    drive_pin(0, c2); idle(5);
    peek(0, v); chk("R3 no B without flag A", v, 16'h0);
    peek(2, v); chk("R3 capB untouched", v, pb);
    drive_pin(1, c3); idle(4); drive_pin(0, c4); idle(5);
    peek(1, v); chk("R3 restart capA", v, c3 + 16'd2);
    peek(2, v); chk("R3 B after restart", v, c4 + 16'd2);

    // filter
    filt = 1; sel_a = 2'b11; sel_b = 2'b11; idle(2);
    drive_pin(1, v); idle(F - 2); drive_pin(0, v); idle(10);
    peek(1, v); chk("R10 short pulse dropped", v, c3 + 16'd2);
    drive_pin(1, c1); idle(F + 2); drive_pin(0, c2); idle(F + 6);
    peek(1, v); chk("R10 filtered capA", v, c1 + 16'd2 + 16'(F));
    peek(2, v); chk("R10 filtered capB", v, c2 + 16'd2 + 16'(F));
    filt = 0;

    // random phase against the model
    do_reset();
    for (int blk = 0; blk < 40; blk++) begin
      @(negedge clk);
      sel_a = 2'($urandom_range(0, 3));
      sel_b = 2'($urandom_range(0, 3));
      cont  = 1'($urandom_range(0, 1));
      feat  = ($urandom_range(0, 7) != 0);
      dual  = ($urandom_range(0, 7) != 0);
      ien_a = 1'($urandom_range(0, 1));
      ien_b = 1'($urandom_range(0, 1));
      if (!cont) sw_write(3'b111);
      for (int cy = 0; cy < 250; cy++) begin
        @(negedge clk);
        if ($urandom_range(0, 3) == 0) pin = ~pin;
        if (cy % 25 == 24) begin
          peek(1, v); chk("R2 R6 random capA", v, m_ca);
          peek(2, v); chk("R3 R4 random capB", v, m_cb);
          peek(0, v); chk("R5 random status", v, {13'd0, m_fb, m_fa, m_arm});
          chk("R7 random irq", {14'd0, irq_b, irq_a},
              {14'd0, m_fb & ien_b, m_fa & ien_a});
        end
      end
    end
    summary();
  end
endmodule